// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This block compares a programmable 16-bit value against the count of one timer, chosen from a bank of free-running timers. When the count first becomes equal to the value, the block acts on a single output latch. It can set the latch, clear it, toggle it or leave it alone. It also raises a sticky interrupt flag. In its trigger mode it sends a one-cycle event that resets the chosen timer, which turns the compare value into a programmable period. The same event can also request an analog-to-digital conversion when the converter is enabled.

Software configures the block through a small write port with three addresses:

| Address | Contents |
|---|---|
| 0 | Control word. Bits [3:0] hold the action code. Bits [6:4] select the timer. |
| 1 | Compare value. |
| 2 | Flag clear. Writing a 1 to bit 0 clears the interrupt flag. |

The timers, the converter and the pin driver are outside the block. Each timer is an input count and receives a reset pulse back from the block.

Top module: `tcmp_unit`

## Requirements
- R1: After a synchronous reset, `out_latch_o`, `irq_flag_o`, `trig_o`, `adc_start_o` and `tmr_clr_o` are all zero.
- R2: Only the timer whose index is in control bits [6:4] is compared. A count on any other timer that equals the compare value has no effect.
- R3: A match changes the latch in the following cycle, according to the action code:
  - code 4'b1000 sets the latch to 1;
  - code 4'b1001 clears the latch to 0;
  - code 4'b0010 inverts the latch.
- R4: A match raises `irq_flag_o` in the following cycle only in the active codes 4'b1000, 4'b1001, 4'b0010, 4'b1010 and 4'b1011. Code 4'b0000 and every other code leave both the flag and the latch untouched.
- R5: The flag stays at 1 until software writes a 1 to bit 0 of address 2. When a match and that clear fall in the same cycle, the flag stays at 1.
- R6: A match acts once, in the first cycle where the count and the compare value become equal. Cycles in which the two stay equal do nothing more.
- R7: In code 4'b1010 a match raises the flag and leaves the latch unchanged.
- R8: In code 4'b1011 a match produces a one-cycle pulse on `trig_o` in the following cycle. In the same cycle, `tmr_clr_o` pulses with only the bit of the selected timer set.
- R9: `adc_start_o` pulses together with `trig_o` only if `adc_en_i` was high in the match cycle. Otherwise it stays low.
- R10: Writing zero to address 0 drives the latch to 0 in the next cycle. A nonzero control write does not change the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_cnt_i | input | NUM_TMR*CNT_W (128) | Packed timer counts, timer k in bits [k*CNT_W +: CNT_W] |
| tmr_clr_o | output | NUM_TMR (8) | One-cycle reset request per timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 compare value, 2 flag clear |
| wr_data_i | input | CNT_W (16) | Write data |
| adc_en_i | input | 1 | Converter enabled |
| out_latch_o | output | 1 | Compare output latch |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| trig_o | output | 1 | Special event trigger pulse |
| adc_start_o | output | 1 | Conversion start pulse |

## Verification
The assertions hold on every cycle for the properties that need no knowledge of the counts:
- a trigger pulse never lasts two cycles;
- timer resets are one-hot and come only with a trigger;
- a conversion start never appears without a trigger;
- the flag never drops unless a clear was written;
- a zero control write always leaves the latch low;
- the software-interrupt code never moves the latch.

Only the bench scenarios can show the value-dependent behaviour:
- which timer is compared;
- the set, clear and toggle results;
- that a held equality fires only once;
- that the trigger resets the selected timer;
- that the set-over-clear race resolves as required.

// File: rtl/tcmp_pkg.sv
// Package: shared constants and helpers for the timer compare unit.
// Assumes: action codes are 4 bits wide; the register map has three addresses.
package tcmp_pkg;
    localparam int MODE_W = 4;
    localparam int ADDR_W = 2;

    localparam logic [MODE_W-1:0] MODE_OFF  = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_TOG  = 4'b0010;
    localparam logic [MODE_W-1:0] MODE_SET  = 4'b1000;
    localparam logic [MODE_W-1:0] MODE_CLR  = 4'b1001;
    localparam logic [MODE_W-1:0] MODE_SWI  = 4'b1010;
    localparam logic [MODE_W-1:0] MODE_TRIG = 4'b1011;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FCLR = 2'd2;

    // True for codes in which a match raises the interrupt flag.
    function automatic logic mode_active(input logic [MODE_W-1:0] m);
        return (m == MODE_SET) || (m == MODE_CLR) || (m == MODE_TOG) ||
               (m == MODE_SWI) || (m == MODE_TRIG);
    endfunction
endpackage

// File: rtl/tcmp_regs.sv
// Register file: holds the control fields and the compare value.
// Decodes the zero-control and flag-clear write strobes.
// Assumes: single-cycle writes; the control fields fit in the low 7 bits of the data bus.
module tcmp_regs
    import tcmp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [MODE_W-1:0]    mode,
    output logic [SEL_W-1:0]     sel,
    output logic [CNT_W-1:0]     cmp_val,
    output logic                 ctrl_zero_wr,
    output logic                 flag_clr
);
    localparam int SEL_LSB = MODE_W;

    // Decode of the write strobes that other stages act on.
    always_comb begin
        ctrl_zero_wr = wr_en && (wr_addr == A_CTRL) && (wr_data == '0);
        flag_clr     = wr_en && (wr_addr == A_FCLR) && wr_data[0];
    end

    // Control and compare value storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_OFF;
            sel     <= '0;
            cmp_val <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                mode <= wr_data[MODE_W-1:0];
                sel  <= wr_data[SEL_LSB +: SEL_W];
            end
            if (wr_addr == A_CMP) begin
                cmp_val <= wr_data;
            end
        end
    end
endmodule

// File: rtl/tcmp_tsel.sv
// Timer selection: picks the compared count from the packed bank.
// Registers a one-hot reset request for the selected timer.
// Assumes: a select index at or above NUM_TMR reads a count of zero and resets nothing.
module tcmp_tsel #(
    parameter int CNT_W   = 16,
    parameter int NUM_TMR = 8,
    parameter int SEL_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_TMR*CNT_W-1:0]   tmr_cnt,
    input  logic [SEL_W-1:0]           sel,
    input  logic                       fire,
    output logic [CNT_W-1:0]           cnt_sel,
    output logic [NUM_TMR-1:0]         tmr_clr
);
    logic [CNT_W-1:0]   cnt_arr [NUM_TMR];
    logic [NUM_TMR-1:0] sel_hot;

    // Unpack the bank and decode the select index to one-hot, one slice per timer.
    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        assign cnt_arr[k] = tmr_cnt[k*CNT_W +: CNT_W];
        assign sel_hot[k] = (sel == SEL_W'(k));
    end

    // Count multiplexer.
    always_comb begin
        cnt_sel = '0;
        for (int k = 0; k < NUM_TMR; k++) begin
            if (sel_hot[k]) cnt_sel = cnt_arr[k];
        end
    end

    // Reset request, registered so that it lines up with the trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_clr <= '0;
        else        tmr_clr <= fire ? sel_hot : '0;
    end
endmodule

// File: rtl/tcmp_detect.sv
// Match detector: flags the first cycle in which the count equals the compare value.
// Assumes: both values are sampled in the same clock domain.
module tcmp_detect #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_sel,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             hit
);
    logic eq_now;
    logic eq_prev;

    // Equality this cycle and the rising-edge qualification.
    always_comb begin
        eq_now = (cnt_sel == cmp_val);
        hit    = eq_now && !eq_prev;
    end

    // Remember last cycle's equality.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_prev <= 1'b0;
        else        eq_prev <= eq_now;
    end
endmodule

// File: rtl/tcmp_action.sv
// Match actions: updates the output latch and the sticky flag.
// Generates the trigger and conversion-start pulses.
// Assumes: at most one hit per cycle; the action code seen is the one stored before the edge.
module tcmp_action
    import tcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [MODE_W-1:0] mode,
    input  logic              ctrl_zero_wr,
    input  logic              flag_clr,
    input  logic              adc_en,
    output logic              fire,
    output logic              out_latch,
    output logic              irq_flag,
    output logic              trig,
    output logic              adc_start
);
    // A trigger fires on a hit in the trigger code.
    always_comb fire = hit && (mode == MODE_TRIG);

    // Output latch: a zero control write wins over any match action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_latch <= 1'b0;
        end else if (ctrl_zero_wr) begin
            out_latch <= 1'b0;
        end else if (hit) begin
            case (mode)
                MODE_SET: out_latch <= 1'b1;
                MODE_CLR: out_latch <= 1'b0;
                MODE_TOG: out_latch <= ~out_latch;
                default:  out_latch <= out_latch;
            endcase
        end
    end

    // Sticky flag: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                        irq_flag <= 1'b0;
        else if (hit && mode_active(mode)) irq_flag <= 1'b1;
        else if (flag_clr)                 irq_flag <= 1'b0;
    end

    // Single-cycle trigger and conversion-start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig      <= 1'b0;
            adc_start <= 1'b0;
        end else begin
            trig      <= fire;
            adc_start <= fire && adc_en;
        end
    end
endmodule

// File: rtl/tcmp_unit.sv
// Top: timer compare unit.
// Selects a timer count, detects the first cycle of equality with the compare value,
// and drives the latch, the flag and the trigger outputs.
// Assumes: the timers run in the same clock domain and honour tmr_clr_o on the next edge.
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_TMR = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_TMR*CNT_W-1:0]   tmr_cnt_i,
    output logic [NUM_TMR-1:0]         tmr_clr_o,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [CNT_W-1:0]           wr_data_i,
    input  logic                       adc_en_i,
    output logic                       out_latch_o,
    output logic                       irq_flag_o,
    output logic                       trig_o,
    output logic                       adc_start_o
);
    localparam int SEL_W = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

    logic [MODE_W-1:0] mode_w;
    logic [SEL_W-1:0]  sel_w;
    logic [CNT_W-1:0]  cmp_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              zero_wr_w;
    logic              fclr_w;
    logic              hit_w;
    logic              fire_w;

    tcmp_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .mode(mode_w), .sel(sel_w), .cmp_val(cmp_w),
        .ctrl_zero_wr(zero_wr_w), .flag_clr(fclr_w)
    );

    tcmp_tsel #(.CNT_W(CNT_W), .NUM_TMR(NUM_TMR), .SEL_W(SEL_W)) u_tsel (
        .clk(clk), .rst_n(rst_n),
        .tmr_cnt(tmr_cnt_i), .sel(sel_w), .fire(fire_w),
        .cnt_sel(cnt_w), .tmr_clr(tmr_clr_o)
    );

    tcmp_detect #(.CNT_W(CNT_W)) u_det (
        .clk(clk), .rst_n(rst_n),
        .cnt_sel(cnt_w), .cmp_val(cmp_w), .hit(hit_w)
    );

    tcmp_action u_act (
        .clk(clk), .rst_n(rst_n),
        .hit(hit_w), .mode(mode_w),
        .ctrl_zero_wr(zero_wr_w), .flag_clr(fclr_w), .adc_en(adc_en_i),
        .fire(fire_w), .out_latch(out_latch_o), .irq_flag(irq_flag_o),
        .trig(trig_o), .adc_start(adc_start_o)
    );
endmodule

// File: rtl/tcmp_unit_chk.sv
// Checker: cycle-level properties of the timer compare unit, bound to the top.
// Assumes: synchronous active-low reset.
module tcmp_unit_chk
    import tcmp_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_TMR = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [CNT_W-1:0]    wr_data,
    input logic [MODE_W-1:0]   mode,
    input logic [NUM_TMR-1:0]  tmr_clr,
    input logic                out_latch,
    input logic                irq_flag,
    input logic                trig,
    input logic                adc_start
);
    logic clr_wr;
    logic ctrl_wr;
    assign clr_wr  = wr_en && (wr_addr == A_FCLR) && wr_data[0];
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    // R8: the trigger lasts a single cycle.
    assert_trig_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    // R8: a trigger comes only from the trigger code.
    assert_trig_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> ($past(mode) == MODE_TRIG));

    // R8: timer resets are one-hot.
    assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_clr));

    // R8: timer resets occur only together with a trigger.
    assert_clr_with_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_clr != '0) |-> trig);

    // R9: a conversion start needs a trigger.
    assert_adc_needs_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> trig);

    // R5: the flag only falls after a clear write.
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !clr_wr) |=> irq_flag);

    // R10: a zero control write leaves the latch low.
    assert_zero_ctrl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && (wr_data == '0)) |=> !out_latch);

    // R7: the software-interrupt code never moves the latch.
    assert_swi_latch_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_SWI) && !ctrl_wr) |=> $stable(out_latch));
endmodule

bind tcmp_unit tcmp_unit_chk #(.CNT_W(CNT_W), .NUM_TMR(NUM_TMR)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .mode(mode_w), .tmr_clr(tmr_clr_o),
    .out_latch(out_latch_o), .irq_flag(irq_flag_o),
    .trig(trig_o), .adc_start(adc_start_o)
);

// File: tb/tcmp_unit_test.sv
// Directed bench for the timer compare unit: one task per scenario.
module tcmp_unit_test;
    localparam int CNT_W   = 16;
    localparam int NUM_TMR = 8;
    localparam time CLK_PERIOD = 10ns;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_TMR*CNT_W-1:0] tmr_cnt;
    logic [NUM_TMR-1:0]       tmr_clr;
    logic                     wr_en = 1'b0;
    logic [1:0]               wr_addr = '0;
    logic [CNT_W-1:0]         wr_data = '0;
    logic                     adc_en = 1'b0;
    logic                     out_latch, irq_flag, trig, adc_start;
    logic [CNT_W-1:0]         tcnt [NUM_TMR];

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int k = 0; k < NUM_TMR; k++) tmr_cnt[k*CNT_W +: CNT_W] = tcnt[k];
    end

    tcmp_unit #(.CNT_W(CNT_W), .NUM_TMR(NUM_TMR)) uut (
        .clk(clk), .rst_n(rst_n), .tmr_cnt_i(tmr_cnt), .tmr_clr_o(tmr_clr),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .adc_en_i(adc_en), .out_latch_o(out_latch), .irq_flag_o(irq_flag),
        .trig_o(trig), .adc_start_o(adc_start)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cnt(input int i, input logic [CNT_W-1:0] v);
        @(negedge clk);
        tcnt[i] = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "latch", 32'(out_latch), 0);
        check("R1", "flag", 32'(irq_flag), 0);
        check("R1", "trig", 32'(trig), 0);
        check("R1", "adc", 32'(adc_start), 0);
        check("R1", "tmr_clr", 32'(tmr_clr), 0);
    endtask

    task automatic t_select_set;
        wr(0, 16'h0018);
        wr(1, 16'd100);
        set_cnt(0, 16'd100);
        check("R2", "unselected flag", 32'(irq_flag), 0);
        check("R2", "unselected latch", 32'(out_latch), 0);
        set_cnt(1, 16'd99);
        check("R3", "no match latch", 32'(out_latch), 0);
        set_cnt(1, 16'd100);
        check("R3", "set latch", 32'(out_latch), 1);
        check("R4", "set flag", 32'(irq_flag), 1);
    endtask

    task automatic t_flag_edge;
        wr(2, 16'h0001);
        check("R5", "flag cleared", 32'(irq_flag), 0);
        repeat (3) @(negedge clk);
        check("R6", "held equality no refire", 32'(irq_flag), 0);
        set_cnt(1, 16'd50);
        @(negedge clk);
        tcnt[1] = 16'd100;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0001;
        @(negedge clk);
        wr_en = 1'b0;
        check("R5", "set beats clear", 32'(irq_flag), 1);
    endtask

    task automatic t_clear_toggle;
        wr(0, 16'h0019);
        check("R10", "nonzero ctrl keeps latch", 32'(out_latch), 1);
        set_cnt(1, 16'd0);
        set_cnt(1, 16'd100);
        check("R3", "clear latch", 32'(out_latch), 0);
        wr(0, 16'h0012);
        set_cnt(1, 16'd1);
        set_cnt(1, 16'd100);
        check("R3", "toggle to 1", 32'(out_latch), 1);
        set_cnt(1, 16'd1);
        set_cnt(1, 16'd100);
        check("R3", "toggle to 0", 32'(out_latch), 0);
        set_cnt(1, 16'd1);
        set_cnt(1, 16'd100);
        check("R3", "toggle back to 1", 32'(out_latch), 1);
    endtask

    task automatic t_swi;
        wr(2, 16'h0001);
        wr(0, 16'h001A);
        set_cnt(1, 16'd1);
        set_cnt(1, 16'd100);
        check("R7", "swi latch held", 32'(out_latch), 1);
        check("R7", "swi flag", 32'(irq_flag), 1);
        check("R7", "swi no trig", 32'(trig), 0);
    endtask

    task automatic t_trigger;
        wr(2, 16'h0001);
        wr(0, 16'h003B);
        adc_en = 1'b0;
        set_cnt(3, 16'd100);
        check("R8", "trig pulse", 32'(trig), 1);
        check("R8", "timer3 reset", 32'(tmr_clr), 32'h08);
        check("R9", "adc off", 32'(adc_start), 0);
        check("R4", "trig flag", 32'(irq_flag), 1);
        tcnt[3] = 16'd0;
        @(negedge clk);
        check("R8", "trig ends", 32'(trig), 0);
        check("R8", "reset ends", 32'(tmr_clr), 0);
        adc_en = 1'b1;
        set_cnt(3, 16'd100);
        check("R9", "adc start", 32'(adc_start), 1);
        check("R8", "trig again", 32'(trig), 1);
        @(negedge clk);
        check("R9", "adc ends", 32'(adc_start), 0);
        adc_en = 1'b0;
    endtask

    task automatic t_inactive;
        wr(2, 16'h0001);
        wr(0, 16'h0015);
        set_cnt(1, 16'd1);
        set_cnt(1, 16'd100);
        check("R4", "code 0101 flag", 32'(irq_flag), 0);
        check("R4", "code 0101 latch", 32'(out_latch), 1);
        wr(0, 16'h0010);
        set_cnt(1, 16'd1);
        set_cnt(1, 16'd100);
        check("R4", "code 0000 flag", 32'(irq_flag), 0);
        check("R4", "code 0000 latch", 32'(out_latch), 1);
        check("R4", "code 0000 trig", 32'(trig), 0);
    endtask

    task automatic t_zero_ctrl;
        wr(0, 16'h0000);
        check("R10", "zero ctrl latch low", 32'(out_latch), 0);
    endtask

    initial begin
        for (int k = 0; k < NUM_TMR; k++) tcnt[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select_set();
        t_flag_edge();
        t_clear_toggle();
        t_swi();
        t_trigger();
        t_inactive();
        t_zero_ctrl();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule